// File: doc/BRIEF.md
# Multiplierless Quarter-Rate Quadrature Mixer

This block moves a stream of real signed samples down to complex baseband. Each sample is multiplied by a phasor whose values are only +1, -j, -1 and +j. The mixing therefore needs sign changes and routing, and no multipliers or sine tables. The in-phase output is the sample times the cosine term. The quadrature output is the sample times the negated sine term. In the normal mode the phasor turns a quarter of a revolution per sample, so a carrier at one quarter of the sample rate lands on DC. A second mode alternates +1 and -1. This flips the spectrum and gives a real result only, with Q held at zero.

Samples enter on a valid/ready stream, one per clock. Results leave through a single output register on a valid/ready stream. The register accepts a new sample when it is empty or when its content is being taken in the same cycle. When the consumer holds `out_ready` low, the result stays in place and `in_ready` drops. The input is expected in symmetric two's complement. The most negative code is clamped to the most negative symmetric value, and a sticky flag records that this happened. Because the input range is symmetric, a negation can never overflow, and I and Q have the same width as the input.

Top module: `quad_mixer`

## Requirements
- R1: With `mode_sel`=0 (quarter rate), accepted samples use phase index k = 0,1,2,3 repeating, starting at 0. The outputs per phase are: k=0 gives I=x, Q=0; k=1 gives I=0, Q=-x; k=2 gives I=-x, Q=0; k=3 gives I=0, Q=+x.
- R2: With `mode_sel`=1 (half rate), accepted samples alternate I=x and I=-x, starting with +x. Q is 0 for every result.
- R3: The phase index advances only on an accepted sample (`in_valid` and `in_ready` both high). Idle cycles and stalled cycles leave it unchanged.
- R4: Synchronous active-low reset. During reset and in the first cycle after it, `out_valid`=0, `out_i`=`out_q`=0 and `sat_flag`=0. The phase index returns to 0.
- R5: When `mode_sel` differs from its value on the previous clock, the phase index restarts. The first sample accepted in the new mode uses phase 0.
- R6: An accepted input equal to the most negative code (-2^(DATA_W-1)) is processed as -(2^(DATA_W-1)-1).
- R7: After the clamp described in R6, `sat_flag` is high from the next cycle on and stays high until reset.
- R8: A sample accepted on a clock edge appears on `out_i`/`out_q` with `out_valid` high right after that edge, which is one cycle of latency.
- R9: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_i` and `out_q` hold and `in_ready` is 0.
- R10: When `out_valid`=0, `in_ready` is 1.
- R11: `out_i` and `out_q` never carry the most negative code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sel | input | 1 | 0 = quarter-rate rotation, 1 = half-rate sideband flip |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample this cycle |
| in_data | input | DATA_W | Real signed input sample |
| out_valid | output | 1 | Output pair valid |
| out_ready | input | 1 | Consumer takes the output pair this cycle |
| out_i | output | DATA_W | In-phase result, signed |
| out_q | output | DATA_W | Quadrature result, signed |
| sat_flag | output | 1 | Sticky: a most-negative input was clamped |

## Verification
Every mixed pair is due one clock after the edge that accepts its sample. The bench drives inputs on the falling edge and decides acceptance from `in_ready` just after that edge. At that moment it pushes the expected pair, computed from its own model of phase and mode. A monitor pops the queue at the same point of every cycle in which `out_valid` and `out_ready` are both high, so a stall delays the comparison and does not skip it. `sat_flag` is due one cycle after the clamped sample is accepted and is checked on the falling edge that follows.

// File: rtl/qmix_pkg.sv
package qmix_pkg;
  typedef enum logic {
    MIX_QUARTER = 1'b0,
    MIX_HALF    = 1'b1
  } mix_mode_e;

  localparam int PHASE_W = 2;
  typedef logic [PHASE_W-1:0] phase_t;

  localparam phase_t PH_ZERO  = 2'd0;
  localparam phase_t PH_ONE   = 2'd1;
  localparam phase_t PH_TWO   = 2'd2;
  localparam phase_t PH_THREE = 2'd3;
endpackage

// File: rtl/qmix_sanitize.sv
module qmix_sanitize #(
  parameter int DATA_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     accept,
  input  logic signed [DATA_W-1:0] raw,
  output logic signed [DATA_W-1:0] clean,
  output logic                     clamped_seen
);
  localparam logic signed [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic signed [DATA_W-1:0] SYM_NEG  = {1'b1, {(DATA_W-2){1'b0}}, 1'b1};

  logic is_most_neg;

  always_comb begin
    is_most_neg = (raw == MOST_NEG);
    clean       = is_most_neg ? SYM_NEG : raw;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clamped_seen <= 1'b0;
    end else if (accept && is_most_neg) begin
      clamped_seen <= 1'b1;
    end
  end
endmodule

// File: rtl/qmix_phase_ctrl.sv
module qmix_phase_ctrl
  import qmix_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  mix_mode_e mode,
  input  logic      accept,
  output phase_t    cur_phase
);
  mix_mode_e mode_q;
  phase_t    phase_q;
  phase_t    step_from;
  phase_t    phase_next;
  logic      mode_changed;

  always_comb begin
    mode_changed = (mode != mode_q);
    cur_phase    = mode_changed ? PH_ZERO : phase_q;
    step_from    = cur_phase;
    if (mode == MIX_HALF) begin
      phase_next = {1'b0, ~step_from[0]};
    end else begin
      phase_next = step_from + PH_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= mode;
      phase_q <= PH_ZERO;
    end else begin
      mode_q <= mode;
      if (accept) begin
        phase_q <= phase_next;
      end else if (mode_changed) begin
        phase_q <= PH_ZERO;
      end
    end
  end
endmodule

// File: rtl/qmix_rotator.sv
module qmix_rotator
  import qmix_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic signed [DATA_W-1:0] sample,
  input  phase_t                   phase,
  input  mix_mode_e                mode,
  output logic signed [DATA_W-1:0] mix_i,
  output logic signed [DATA_W-1:0] mix_q
);
  logic signed [DATA_W-1:0] neg_sample;

  always_comb begin
    neg_sample = -sample;
    mix_i = '0;
    mix_q = '0;
    if (mode == MIX_HALF) begin
      mix_i = phase[0] ? neg_sample : sample;
    end else begin
      unique case (phase)
        PH_ZERO:  mix_i = sample;
        PH_ONE:   mix_q = neg_sample;
        PH_TWO:   mix_i = neg_sample;
        PH_THREE: mix_q = sample;
        default:  mix_i = '0;
      endcase
    end
  end
endmodule

// File: rtl/quad_mixer.sv
module quad_mixer
  import qmix_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mode_sel,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [DATA_W-1:0] out_i,
  output logic signed [DATA_W-1:0] out_q,
  output logic                     sat_flag
);
  mix_mode_e                mode;
  logic                     accept;
  logic signed [DATA_W-1:0] clean;
  phase_t                   phase;
  logic signed [DATA_W-1:0] mix_i;
  logic signed [DATA_W-1:0] mix_q;

  always_comb begin
    mode     = mix_mode_e'(mode_sel);
    in_ready = !out_valid || out_ready;
    accept   = in_valid && in_ready;
  end

  qmix_sanitize #(.DATA_W(DATA_W)) u_sanitize (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept       (accept),
    .raw          (in_data),
    .clean        (clean),
    .clamped_seen (sat_flag)
  );

  qmix_phase_ctrl u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .accept    (accept),
    .cur_phase (phase)
  );

  qmix_rotator #(.DATA_W(DATA_W)) u_rot (
    .sample (clean),
    .phase  (phase),
    .mode   (mode),
    .mix_i  (mix_i),
    .mix_q  (mix_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_i <= mix_i;
        out_q <= mix_q;
      end
    end
  end
endmodule

// File: rtl/qmix_checker.sv
module qmix_checker #(
  parameter int DATA_W = 12
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     mode_sel,
  input logic                     in_valid,
  input logic                     in_ready,
  input logic signed [DATA_W-1:0] in_data,
  input logic                     out_valid,
  input logic                     out_ready,
  input logic signed [DATA_W-1:0] out_i,
  input logic signed [DATA_W-1:0] out_q,
  input logic                     sat_flag
);
  localparam logic signed [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  // R11
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_i != MOST_NEG) && (out_q != MOST_NEG));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_i) && $stable(out_q));

  // R9
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R10
  empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R8
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R2
  half_q_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && mode_sel) |=> (out_q == '0));

  // R7
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat_flag |=> sat_flag);

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_data == MOST_NEG)) |=> sat_flag);
endmodule

bind quad_mixer qmix_checker #(.DATA_W(DATA_W)) u_qmix_chk (.*);

// File: tb/quad_mixer_bench.sv
module quad_mixer_bench;
  localparam int W = 12;
  localparam int MAXV = (1 << (W-1)) - 1;
  localparam int MINV = -(1 << (W-1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_sel = 1'b0;
  logic in_valid = 1'b0;
  logic signed [W-1:0] in_data = '0;
  logic out_ready = 1'b1;
  logic in_ready, out_valid, sat_flag;
  logic signed [W-1:0] out_i, out_q;

  int checks = 0;
  int errors = 0;
  int mdl_phase = 0;
  logic mdl_mode = 1'b0;
  int exp_i_q[$];
  int exp_q_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  quad_mixer #(.DATA_W(W)) u_quad_mixer (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_i(out_i), .out_q(out_q), .sat_flag(sat_flag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one sample with a given mode; model computes expected pair on acceptance
  task automatic send(input int x, input logic m, input string req);
    int xs, ei, eq;
    @(negedge clk);
    mode_sel = m;
    in_valid = 1'b1;
    in_data  = x[W-1:0];
    if (m != mdl_mode) begin
      mdl_phase = 0;
      mdl_mode  = m;
    end
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    xs = (x == MINV) ? -MAXV : x;
    ei = 0; eq = 0;
    if (m) begin
      ei = (mdl_phase % 2 == 0) ? xs : -xs;
      mdl_phase = (mdl_phase + 1) % 2;
    end else begin
      case (mdl_phase)
        0: ei = xs;
        1: eq = -xs;
        2: ei = -xs;
        default: eq = xs;
      endcase
      mdl_phase = (mdl_phase + 1) % 4;
    end
    exp_i_q.push_back(ei);
    exp_q_q.push_back(eq);
    tag_q.push_back(req);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare each transferred output pair with the queue
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && out_valid && out_ready) begin
        if (exp_i_q.size() == 0) begin
          check(1'b0, "R8 unexpected output", int'(out_i), 0);
        end else begin
          int ei, eq;
          string t;
          ei = exp_i_q.pop_front();
          eq = exp_q_q.pop_front();
          t = tag_q.pop_front();
          check(int'(out_i) == ei, {t, " I"}, int'(out_i), ei);
          check(int'(out_q) == eq, {t, " Q"}, int'(out_q), eq);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R4 out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    mdl_mode = 1'b0;
    mdl_phase = 0;
    @(negedge clk);
    check(out_valid == 1'b0, "R4 out_valid after reset", out_valid, 0);
    check(out_i == '0 && out_q == '0, "R4 outputs zero", int'(out_i), 0);
    check(sat_flag == 1'b0, "R4 sat_flag clear", sat_flag, 0);
    check(in_ready == 1'b1, "R10 ready when empty", in_ready, 1);

    // R1 quarter-rate rotation, two full turns, back to back
    send(100, 1'b0, "R1 k0");
    send(200, 1'b0, "R1 k1");
    send(-300, 1'b0, "R1 k2");
    send(400, 1'b0, "R1 k3");
    send(MAXV, 1'b0, "R1 wrap k0");
    send(-MAXV, 1'b0, "R1 k1 neg");
    send(7, 1'b0, "R1 k2");
    send(-9, 1'b0, "R1 k3");
    // R3 gaps do not advance the phase
    send(55, 1'b0, "R3 k0 before gap");
    idle(3);
    send(66, 1'b0, "R3 k1 after gap");
    idle(1);
    send(77, 1'b0, "R3 k2 after gap");
    // R5 mode change on an accepted sample restarts at phase 0
    send(123, 1'b1, "R5 R2 first half sample +x");
    send(123, 1'b1, "R2 second half sample -x");
    send(-50, 1'b1, "R2 third half sample");
    idle(2);
    // R5 mode change on an idle cycle, then quarter restarts at 0
    @(negedge clk); mode_sel = 1'b0; mdl_mode = 1'b0; mdl_phase = 0;
    idle(2);
    send(31, 1'b0, "R5 quarter restart k0");
    send(32, 1'b0, "R5 quarter k1");
    // R6 R7 clamp of the most negative code
    @(negedge clk);
    check(sat_flag == 1'b0, "R7 flag before clamp", sat_flag, 0);
    send(MINV, 1'b0, "R6 clamp k2");
    @(negedge clk);
    check(sat_flag == 1'b1, "R7 flag after clamp", sat_flag, 1);
    send(MINV, 1'b0, "R6 R11 clamp k3");
    idle(3);
    check(sat_flag == 1'b1, "R7 flag sticky", sat_flag, 1);

    // R9 back-pressure: output held while out_ready low
    @(negedge clk); out_ready = 1'b0;
    send(250, 1'b0, "R9 held k0");
    idle(1);
    #1;
    check(out_valid == 1'b1, "R9 valid held", out_valid, 1);
    check(in_ready == 1'b0, "R9 ready low while stalled", in_ready, 0);
    check(int'(out_i) == 250, "R9 data held", int'(out_i), 250);
    fork
      send(-251, 1'b0, "R9 R3 k1 after stall");
      begin idle(4); out_ready = 1'b1; end
    join
    idle(3);
    check(exp_i_q.size() == 0, "R8 all results delivered", exp_i_q.size(), 0);

    // R4 reset clears flag and phase
    @(negedge clk); rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1; mdl_phase = 0; mdl_mode = mode_sel;
    @(negedge clk);
    check(sat_flag == 1'b0, "R4 flag cleared by reset", sat_flag, 0);
    send(90, 1'b0, "R4 phase 0 after reset");
    idle(3);
    check(exp_i_q.size() == 0, "R8 queue empty at end", exp_i_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule